// File: doc/BRIEF.md
# Grouped Interrupt Priority Arbiter

This block picks the most urgent interrupt for one processor from a small, fixed set of sources. Each source has a pending bit, an enable bit, an 8-bit priority (a lower value is more urgent) and a one-bit group tag. On every clock the arbiter looks at all sources that are both pending and enabled and finds the lowest priority value. When two sources share a priority, the lower source number wins. It then records that source as the highest pending interrupt and decides whether to raise the normal interrupt line, the fast interrupt line, or neither.

The decision is gated at two levels. The first level is a pair of distributor group enables. The second is a pair of CPU-interface group enables. The winner is reported only when it beats the priority mask, and a line is raised only when the winner also beats the running priority. A group 0 winner uses the fast line when the fast-routing bit is set. All other qualifying winners use the normal line. The outputs are registered, so they follow the inputs sampled at the previous rising edge.

Top module: `grp_prio_arbiter`

## Requirements
- R1: While reset is held and on the first edge after it, `hp_id` is 1023 and both `irq_o` and `fiq_o` are low.
- R2: If `dist_grp_en` is 2'b00 or `cpu_grp_en` is 2'b00, then after the next edge `hp_id` is 1023 and both lines are low, whatever the sources hold.
- R3: A source takes part only when both its pending bit and its enable bit are 1. Among the sources that take part, the one with the numerically lowest priority wins. A pending source that is disabled has no effect on `hp_id`.
- R4: When several sources share the lowest priority, the one with the lowest index wins.
- R5: The winner's index appears on `hp_id` only if its priority is strictly below `prio_mask`. Otherwise `hp_id` is 1023 and both lines are low. With no source taking part, `hp_id` is 1023.
- R6: A line is raised only if the winner's priority, zero-extended, is strictly below the 9-bit `run_prio`. The value 0x100 means nothing is running. When the winner does not beat `run_prio`, `hp_id` still shows the winner.
- R7: Group bit 0 means group 0 and 1 means group 1. Bit g of `dist_grp_en` and bit g of `cpu_grp_en` enable group g. A line is raised only when both enables for the winner's group are 1. Otherwise both lines stay low, but `hp_id` still shows the winner.
- R8: A qualifying group 0 winner raises `fiq_o` when `fiq_route` is 1 and `irq_o` when it is 0. A qualifying group 1 winner always raises `irq_o`.
- R9: `irq_o` and `fiq_o` are never high in the same cycle.
- R10: All outputs are registered with one cycle of latency. They reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pending | input | NUM_SRC | Pending bit for each source |
| src_enable | input | NUM_SRC | Enable bit for each source |
| src_group | input | NUM_SRC | Group tag for each source (0 or 1) |
| src_prio | input | NUM_SRC*PRIO_W | Packed priorities; source i is at bits [i*PRIO_W +: PRIO_W] |
| dist_grp_en | input | 2 | Distributor enable for group 0 (bit 0) and group 1 (bit 1) |
| cpu_grp_en | input | 2 | CPU-interface enable for group 0 (bit 0) and group 1 (bit 1) |
| fiq_route | input | 1 | Sends group 0 winners to the fast line |
| prio_mask | input | PRIO_W | Priority mask; the winner must be strictly below it |
| run_prio | input | PRIO_W+1 | Running priority; 0x100 means idle |
| hp_id | output | 10 | Highest pending source index, or 1023 for none |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The bench builds the arbiter with 12 sources and 8-bit priorities. Because 12 is not a power of two, the selection tree has padding leaves, and the bench can show that they never win. With 8-bit priorities it can reach the edge cases directly: a priority of 0xFF against a mask of 0xFF, and an idle running priority of 0x100 that any winner beats. A behavioural model runs alongside the design and is compared every cycle. Random traffic draws its priorities from a few coarse values, so ties between sources and mixed groups come up often.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
  localparam int unsigned GPA_ID_W = 10;
  localparam logic [GPA_ID_W-1:0] GPA_NONE_ID = 10'd1023;

  typedef enum logic [1:0] {
    LINE_NONE = 2'b00,
    LINE_IRQ  = 2'b01,
    LINE_FIQ  = 2'b10
  } line_sel_e;

  // Left contender keeps the slot on equal priority (it has the lower index).
  function automatic logic left_keeps(input logic lv, input logic rv,
                                      input int unsigned lp, input int unsigned rp);
    return lv && (!rv || (lp <= rp));
  endfunction

  // Line choice for a winner that has passed every gate.
  function automatic line_sel_e pick_line(input logic grp, input logic fast_route);
    return (!grp && fast_route) ? LINE_FIQ : LINE_IRQ;
  endfunction
endpackage

// File: rtl/gpa_select_tree.sv
module gpa_select_tree
  import gpa_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] cand_prio,
  input  logic [NUM_SRC-1:0]        cand_grp,
  output logic                      win_valid,
  output logic [PRIO_W-1:0]         win_prio,
  output logic [GPA_ID_W-1:0]       win_id,
  output logic                      win_grp
);
  localparam int unsigned LEVELS = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
  localparam int unsigned LEAVES = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic                nd_v   [NODES];
  logic [PRIO_W-1:0]   nd_p   [NODES];
  logic [GPA_ID_W-1:0] nd_id  [NODES];
  logic                nd_g   [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      assign nd_v [LEAVES-1+i] = cand[i];
      assign nd_p [LEAVES-1+i] = cand_prio[i*PRIO_W +: PRIO_W];
      assign nd_id[LEAVES-1+i] = GPA_ID_W'(i);
      assign nd_g [LEAVES-1+i] = cand_grp[i];
    end else begin : g_pad
      assign nd_v [LEAVES-1+i] = 1'b0;
      assign nd_p [LEAVES-1+i] = '1;
      assign nd_id[LEAVES-1+i] = GPA_NONE_ID;
      assign nd_g [LEAVES-1+i] = 1'b0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic keep_l;
    assign keep_l     = left_keeps(nd_v[2*k+1], nd_v[2*k+2],
                                   int'(nd_p[2*k+1]), int'(nd_p[2*k+2]));
    assign nd_v [k]   = nd_v[2*k+1] | nd_v[2*k+2];
    assign nd_p [k]   = keep_l ? nd_p [2*k+1] : nd_p [2*k+2];
    assign nd_id[k]   = keep_l ? nd_id[2*k+1] : nd_id[2*k+2];
    assign nd_g [k]   = keep_l ? nd_g [2*k+1] : nd_g [2*k+2];
  end

  assign win_valid = nd_v[0];
  assign win_prio  = nd_p[0];
  assign win_id    = nd_id[0];
  assign win_grp   = nd_g[0];

  // R3: a reported winner must be a real, participating source
  always_comb begin
    if (win_valid) begin
      assert_winner_real_R3: assert (int'(win_id) < NUM_SRC);
    end
  end
endmodule

// File: rtl/gpa_line_route.sv
module gpa_line_route
  import gpa_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              win_valid,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              win_grp,
  input  logic [1:0]        dist_grp_en,
  input  logic [1:0]        cpu_grp_en,
  input  logic              fiq_route,
  input  logic [PRIO_W-1:0] prio_mask,
  input  logic [PRIO_W:0]   run_prio,
  output logic              report_ok,
  output line_sel_e         line_sel
);
  logic gate_open, below_mask, preempts, grp_on;

  assign gate_open  = (|dist_grp_en) && (|cpu_grp_en);
  assign below_mask = win_valid && (win_prio < prio_mask);
  assign preempts   = {1'b0, win_prio} < run_prio;
  assign grp_on     = dist_grp_en[win_grp] && cpu_grp_en[win_grp];
  assign report_ok  = gate_open && below_mask;

  always_comb begin
    line_sel = LINE_NONE;
    if (report_ok && preempts && grp_on) begin
      line_sel = pick_line(win_grp, fiq_route);
    end
  end
endmodule

// File: rtl/grp_prio_arbiter.sv
module grp_prio_arbiter
  import gpa_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_pending,
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC-1:0]        src_group,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [1:0]                dist_grp_en,
  input  logic [1:0]                cpu_grp_en,
  input  logic                      fiq_route,
  input  logic [PRIO_W-1:0]         prio_mask,
  input  logic [PRIO_W:0]           run_prio,
  output logic [GPA_ID_W-1:0]       hp_id,
  output logic                      irq_o,
  output logic                      fiq_o
);
  logic [NUM_SRC-1:0]  cand;
  logic                win_valid;
  logic [PRIO_W-1:0]   win_prio;
  logic [GPA_ID_W-1:0] win_id;
  logic                win_grp;
  logic                report_ok;
  line_sel_e           line_sel;

  assign cand = src_pending & src_enable;

  gpa_select_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
    .cand      (cand),
    .cand_prio (src_prio),
    .cand_grp  (src_group),
    .win_valid (win_valid),
    .win_prio  (win_prio),
    .win_id    (win_id),
    .win_grp   (win_grp)
  );

  gpa_line_route #(.PRIO_W(PRIO_W)) u_route (
    .win_valid   (win_valid),
    .win_prio    (win_prio),
    .win_grp     (win_grp),
    .dist_grp_en (dist_grp_en),
    .cpu_grp_en  (cpu_grp_en),
    .fiq_route   (fiq_route),
    .prio_mask   (prio_mask),
    .run_prio    (run_prio),
    .report_ok   (report_ok),
    .line_sel    (line_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_id <= GPA_NONE_ID;
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      hp_id <= report_ok ? win_id : GPA_NONE_ID;
      irq_o <= (line_sel == LINE_IRQ);
      fiq_o <= (line_sel == LINE_FIQ);
    end
  end

  // R9: lines are exclusive
  assert_lines_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));

  // R2: no group open at either level gives the idle outputs
  assert_closed_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((dist_grp_en == 2'b00) || (cpu_grp_en == 2'b00)) |=>
      (hp_id == GPA_NONE_ID && !irq_o && !fiq_o));

  // R5: a reported index came from a winner below the mask
  assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !(win_prio < prio_mask)) |=> (hp_id == GPA_NONE_ID && !irq_o && !fiq_o));

  // R6: a raised line needs a winner that beats the running priority
  assert_preempt_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !({1'b0, win_prio} < run_prio) |=> (!irq_o && !fiq_o));

  // R7: a raised line needs both enables of the winner's group
  assert_group_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dist_grp_en[win_grp] && cpu_grp_en[win_grp]) |=> (!irq_o && !fiq_o));

  // R8: the fast line only carries group 0 winners with routing on
  assert_fast_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_grp || !fiq_route) |=> !fiq_o);
endmodule

// File: tb/grp_prio_arbiter_test.sv
`timescale 1ns/1ps
module grp_prio_arbiter_test;
  localparam int NS = 12;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]    src_pending, src_enable, src_group;
  logic [NS*PW-1:0] src_prio;
  logic [1:0]       dist_grp_en, cpu_grp_en;
  logic             fiq_route;
  logic [PW-1:0]    prio_mask;
  logic [PW:0]      run_prio;
  logic [9:0]       hp_id;
  logic             irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grp_prio_arbiter #(.NUM_SRC(NS), .PRIO_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .src_pending(src_pending), .src_enable(src_enable),
    .src_group(src_group), .src_prio(src_prio), .dist_grp_en(dist_grp_en),
    .cpu_grp_en(cpu_grp_en), .fiq_route(fiq_route), .prio_mask(prio_mask),
    .run_prio(run_prio), .hp_id(hp_id), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  int m_id;
  bit m_irq, m_fiq;

  // Behavioural model of the selection rules over the current inputs
  task automatic model();
    int best_p = 256;
    int best_i = -1;
    m_id = 1023; m_irq = 0; m_fiq = 0;
    if (dist_grp_en == 2'b00 || cpu_grp_en == 2'b00) return;
    for (int i = 0; i < NS; i++) begin
      int p = int'(src_prio[i*PW +: PW]);
      if (src_pending[i] && src_enable[i] && p < best_p) begin
        best_p = p; best_i = i;
      end
    end
    if (best_i < 0 || best_p >= int'(prio_mask)) return;
    m_id = best_i;
    if (best_p < int'(run_prio)) begin
      int g = int'(src_group[best_i]);
      if (dist_grp_en[g] && cpu_grp_en[g]) begin
        if (g == 0 && fiq_route) m_fiq = 1; else m_irq = 1;
      end
    end
  endtask

  task automatic check(string tag, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Sample model now, step one edge, compare just after it (R10 latency)
  task automatic step(string tag);
    model();
    @(posedge clk); #1;
    check(tag, hp_id == 10'(m_id), "hp_id", int'(hp_id), m_id);
    check(tag, irq_o == m_irq && fiq_o == m_fiq, "irq/fiq",
          int'({irq_o, fiq_o}), int'({m_irq, m_fiq}));
    check("R9", !(irq_o && fiq_o), "both lines", int'({irq_o, fiq_o}), 2);
  endtask

  task automatic set_src(int i, bit pend, bit en, bit grp, int p);
    src_pending[i] = pend; src_enable[i] = en; src_group[i] = grp;
    src_prio[i*PW +: PW] = PW'(p);
  endtask

  initial begin
    src_pending = '0; src_enable = '0; src_group = '0; src_prio = '1;
    dist_grp_en = 2'b11; cpu_grp_en = 2'b11; fiq_route = 1'b0;
    prio_mask = 8'hFF; run_prio = 9'h100;
    set_src(4, 1, 1, 1, 8'h10);
    repeat (3) @(posedge clk);
    #1;
    check("R1", hp_id == 10'd1023 && !irq_o && !fiq_o, "reset outputs",
          int'(hp_id), 1023);
    rst_n = 1'b1;
    check("R1", hp_id == 10'd1023 && !irq_o && !fiq_o, "after release",
          int'(hp_id), 1023);
    src_pending = '0;
    step("R10");

    set_src(3, 1, 1, 1, 8'h40); step("R3 single");
    set_src(7, 1, 1, 1, 8'h20); step("R3 lower wins");
    set_src(9, 1, 0, 1, 8'h10); step("R3 disabled ignored");
    check("R3", hp_id == 10'd7, "disabled source", int'(hp_id), 7);
    set_src(2, 1, 1, 1, 8'h20); step("R4 tie");
    check("R4", hp_id == 10'd2, "tie index", int'(hp_id), 2);

    prio_mask = 8'h20; step("R5 at mask");
    check("R5", hp_id == 10'd1023, "masked", int'(hp_id), 1023);
    prio_mask = 8'h21; step("R5 below mask");
    run_prio = 9'h020; step("R6 no preempt");
    check("R6", hp_id == 10'd2 && !irq_o, "id kept line low", int'(irq_o), 0);
    run_prio = 9'h021; step("R6 preempt");
    check("R6", irq_o == 1'b1, "line up", int'(irq_o), 1);
    prio_mask = 8'hFF; run_prio = 9'h100;

    set_src(2, 1, 1, 0, 8'h20); fiq_route = 1'b1; step("R8 g0 fast");
    check("R8", fiq_o && !irq_o, "fast line", int'(fiq_o), 1);
    fiq_route = 1'b0; step("R8 g0 normal");
    check("R8", irq_o && !fiq_o, "normal line", int'(irq_o), 1);
    fiq_route = 1'b1; cpu_grp_en = 2'b10; step("R7 cpu g0 off");
    check("R7", hp_id == 10'd2 && !irq_o && !fiq_o, "gated", int'({irq_o, fiq_o}), 0);
    cpu_grp_en = 2'b11; dist_grp_en = 2'b10; step("R7 dist g0 off");
    dist_grp_en = 2'b00; step("R2 dist closed");
    check("R2", hp_id == 10'd1023, "dist closed", int'(hp_id), 1023);
    dist_grp_en = 2'b11; cpu_grp_en = 2'b00; step("R2 cpu closed");
    cpu_grp_en = 2'b11;

    src_pending = '0; set_src(11, 1, 1, 1, 8'hFF); step("R5 prio FF");
    check("R5", hp_id == 10'd1023, "FF vs mask FF", int'(hp_id), 1023);
    src_pending = '0; step("R5 none");

    for (int c = 0; c < 400; c++) begin
      for (int i = 0; i < NS; i++)
        set_src(i, $urandom_range(0, 1), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 1), $urandom_range(0, 4) * 60);
      dist_grp_en = 2'($urandom_range(0, 3));
      cpu_grp_en  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) begin dist_grp_en = 2'b11; cpu_grp_en = 2'b11; end
      fiq_route = 1'($urandom_range(0, 1));
      prio_mask = 8'($urandom_range(0, 4) * 64);
      if ($urandom_range(0, 1) == 1) prio_mask = 8'hFF;
      run_prio  = 9'($urandom_range(0, 4) * 64);
      step("R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule